// File: doc/BRIEF.md
# Prefetch Reuse Trainer

This block learns, for each hardware prefetcher, whether the lines it brings in are worth keeping in the second and third cache levels. It holds one saturating reuse counter and one insert/bypass hint per prefetcher and per level. Lines carry a small prefetcher identifier in their tag. The identifier is zero for regular lines. A nonzero value names the prefetcher that fetched the line and marks that the line has not yet served a demand.

The cache reports one event per cycle: either a hit, with its request type and level, or the eviction of an unused line, with its level. Each event carries the line's current identifier. The trainer steps the matching counter and updates the hint. One cycle later it presents the identifier to write back into the tag, a request to add the address to the demand footprint filter, and a request to train the demand predictor. The demand predictor uses the same PC to look up fresh hints. Prefetcher entries need no footprint filter, because the identifier in the tag already names the owner.

Top module: `pf_reuse_trainer`

## Requirements
- R1: After reset every counter holds its maximum (7 for 3-bit counters), every hint is Insert (1), and `id_wr_valid`, `fp_add_valid` and `dem_upd_valid` are low.
- R2: A demand hit (`ev_hit`=1, `ev_demand`=1) on a prefetched line (`ev_line_id` in 1..NUM_PF) increments the counter of that prefetcher for the hit level (`ev_lvl` 0 = second level, 1 = third level). The new value is visible on `pf_cnt` one cycle later. Entry e=(id-1)*NUM_LVL+lvl occupies bits [e*CNT_W +: CNT_W] of `pf_cnt` and bit e of `pf_hint`.
- R3: One cycle after that demand hit, the trainer raises `id_wr_valid` with `id_wr_value`=0. In the same cycle it raises `fp_add_valid` with the event address, and `dem_upd_valid` with the event level and PC. Each of these is a single-cycle pulse.
- R4: A prefetch hit (`ev_hit`=1, `ev_demand`=0) on a prefetched line increments the counter of the line's prefetcher at the hit level. It raises no identifier write and no demand request.
- R5: A prefetch hit on a regular line (`ev_line_id`=0) whose requester `ev_req_id` is in 1..NUM_PF makes the trainer raise `id_wr_valid` one cycle later with `id_wr_value`=`ev_req_id`. No counter or hint changes.
- R6: An unused eviction (`ev_hit`=0) of a prefetched line decrements the counter of the line's prefetcher at the evicting level. It raises no identifier write and no demand request.
- R7: A hint becomes Insert when its counter reaches the maximum and Bypass (0) when its counter reaches zero. At any other value the hint keeps its previous value.
- R8: Counters saturate: an increment at the maximum and a decrement at zero leave the counter unchanged.
- R9: An event with `ev_valid` low, a demand hit or eviction of a regular line, or a prefetch hit on a regular line with requester 0 changes no counter or hint and raises no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Cache event present this cycle |
| ev_hit | input | 1 | 1 = hit, 0 = unused eviction |
| ev_demand | input | 1 | Hit request type: 1 = demand, 0 = prefetch |
| ev_lvl | input | LVL_W | Cache level of the event (0 = second, 1 = third) |
| ev_line_id | input | PFID_W | Prefetcher identifier currently stored with the line |
| ev_req_id | input | PFID_W | Identifier of the requesting prefetcher on a prefetch hit |
| ev_addr | input | ADDR_W | Line address of the event |
| ev_pc | input | PC_W | PC of the demand request |
| id_wr_valid | output | 1 | Write a new identifier into the line's tag |
| id_wr_value | output | PFID_W | Identifier to write |
| fp_add_valid | output | 1 | Add the address to the demand footprint filter |
| fp_add_addr | output | ADDR_W | Address to add |
| dem_upd_valid | output | 1 | Train the demand entry and fetch fresh hints |
| dem_upd_lvl | output | LVL_W | Level at which the demand reuse occurred |
| dem_upd_pc | output | PC_W | Demand PC used for training and hint lookup |
| pf_cnt | output | NUM_PF*NUM_LVL*CNT_W | All prefetcher reuse counters |
| pf_hint | output | NUM_PF*NUM_LVL | All prefetcher hints, 1 = Insert |

## Verification
A demand hit on a prefetched line does several things on the same edge. It advances a prefetcher counter, and it issues the tag write, the footprint add and the demand training request. The bench drives demand hits while counters sit below, at and just under the maximum. After every event it checks the full counter and hint vectors together with all three request pulses against a model in the bench. A counter that moves without the requests, or requests that fire without the counter moving, is reported. Sweeps over every prefetcher and level walk each counter from full to empty and back. These sweeps exercise both saturation points and the hold behaviour of the hint between them.

// File: rtl/pft_pkg.sv
package pft_pkg;

   // Classified cache event as seen by the trainer
   typedef enum logic [2:0] {
      EV_NONE       = 3'd0,
      EV_DEM_HIT_PF = 3'd1,   // demand hit on a prefetched line
      EV_PF_HIT_PF  = 3'd2,   // prefetch hit on a prefetched line
      EV_PF_HIT_REG = 3'd3,   // prefetch hit on a regular line
      EV_EVICT_PF   = 3'd4    // unused eviction of a prefetched line
   } ev_class_e;

   localparam logic HINT_INSERT = 1'b1;
   localparam logic HINT_BYPASS = 1'b0;

endpackage

// File: rtl/pft_classify.sv
module pft_classify
   import pft_pkg::*;
#(
   parameter int unsigned PFID_W  = 2,
   parameter int unsigned NUM_PF  = 3,
   parameter int unsigned NUM_LVL = 2,
   parameter int unsigned LVL_W   = 1
) (
   input  logic              ev_valid,
   input  logic              ev_hit,
   input  logic              ev_demand,
   input  logic [LVL_W-1:0]  ev_lvl,
   input  logic [PFID_W-1:0] ev_line_id,
   input  logic [PFID_W-1:0] ev_req_id,
   output ev_class_e         cls
);

   logic line_pf;
   logic line_reg;
   logic req_ok;
   logic lvl_ok;

   always_comb begin
      line_pf  = (ev_line_id != '0) && (32'(ev_line_id) <= NUM_PF);
      line_reg = (ev_line_id == '0);
      req_ok   = (ev_req_id != '0) && (32'(ev_req_id) <= NUM_PF);
      lvl_ok   = (32'(ev_lvl) < NUM_LVL);
   end

   always_comb begin
      cls = EV_NONE;
      if (ev_valid && lvl_ok) begin
         if (ev_hit) begin
            if (ev_demand) begin
               if (line_pf) cls = EV_DEM_HIT_PF;
            end else if (line_pf) begin
               cls = EV_PF_HIT_PF;
            end else if (line_reg && req_ok) begin
               cls = EV_PF_HIT_REG;
            end
         end else if (line_pf) begin
            cls = EV_EVICT_PF;
         end
      end
   end

endmodule

// File: rtl/pft_entry.sv
module pft_entry
   import pft_pkg::*;
#(
   parameter int unsigned CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   output logic [CNT_W-1:0] cnt,
   output logic             hint
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_nx;
   logic             hint_nx;

   always_comb begin
      cnt_nx = cnt;
      if (inc && !dec && cnt != CNT_MAX)
         cnt_nx = cnt + 1'b1;
      else if (dec && !inc && cnt != '0)
         cnt_nx = cnt - 1'b1;
   end

   // hint switches only at the two ends of the counter range
   always_comb begin
      hint_nx = hint;
      if (cnt_nx == CNT_MAX)
         hint_nx = HINT_INSERT;
      else if (cnt_nx == '0)
         hint_nx = HINT_BYPASS;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= CNT_MAX;
         hint <= HINT_INSERT;
      end else begin
         cnt  <= cnt_nx;
         hint <= hint_nx;
      end
   end

endmodule

// File: rtl/pft_resp.sv
module pft_resp
   import pft_pkg::*;
#(
   parameter int unsigned PFID_W = 2,
   parameter int unsigned LVL_W  = 1,
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned PC_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ev_class_e         cls,
   input  logic [LVL_W-1:0]  ev_lvl,
   input  logic [PFID_W-1:0] ev_req_id,
   input  logic [ADDR_W-1:0] ev_addr,
   input  logic [PC_W-1:0]   ev_pc,
   output logic              id_wr_valid,
   output logic [PFID_W-1:0] id_wr_value,
   output logic              fp_add_valid,
   output logic [ADDR_W-1:0] fp_add_addr,
   output logic              dem_upd_valid,
   output logic [LVL_W-1:0]  dem_upd_lvl,
   output logic [PC_W-1:0]   dem_upd_pc
);

   logic promote;
   logic claim;

   always_comb begin
      promote = (cls == EV_DEM_HIT_PF);
      claim   = (cls == EV_PF_HIT_REG);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         id_wr_valid   <= 1'b0;
         id_wr_value   <= '0;
         fp_add_valid  <= 1'b0;
         fp_add_addr   <= '0;
         dem_upd_valid <= 1'b0;
         dem_upd_lvl   <= '0;
         dem_upd_pc    <= '0;
      end else begin
         id_wr_valid   <= promote || claim;
         id_wr_value   <= claim ? ev_req_id : '0;
         fp_add_valid  <= promote;
         fp_add_addr   <= promote ? ev_addr : '0;
         dem_upd_valid <= promote;
         dem_upd_lvl   <= promote ? ev_lvl : '0;
         dem_upd_pc    <= promote ? ev_pc : '0;
      end
   end

endmodule

// File: rtl/pf_reuse_trainer.sv
module pf_reuse_trainer
   import pft_pkg::*;
#(
   parameter int unsigned NUM_PF  = 3,
   parameter int unsigned PFID_W  = 2,
   parameter int unsigned NUM_LVL = 2,
   parameter int unsigned CNT_W   = 3,
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned PC_W    = 16,
   localparam int unsigned LVL_W   = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1,
   localparam int unsigned NUM_ENT = NUM_PF * NUM_LVL
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ev_valid,
   input  logic                       ev_hit,
   input  logic                       ev_demand,
   input  logic [LVL_W-1:0]           ev_lvl,
   input  logic [PFID_W-1:0]          ev_line_id,
   input  logic [PFID_W-1:0]          ev_req_id,
   input  logic [ADDR_W-1:0]          ev_addr,
   input  logic [PC_W-1:0]            ev_pc,
   output logic                       id_wr_valid,
   output logic [PFID_W-1:0]          id_wr_value,
   output logic                       fp_add_valid,
   output logic [ADDR_W-1:0]          fp_add_addr,
   output logic                       dem_upd_valid,
   output logic [LVL_W-1:0]           dem_upd_lvl,
   output logic [PC_W-1:0]            dem_upd_pc,
   output logic [NUM_ENT*CNT_W-1:0]   pf_cnt,
   output logic [NUM_ENT-1:0]         pf_hint
);

   // elaboration-time parameter checks
   if (NUM_PF < 1 || NUM_PF >= (1 << PFID_W)) begin : g_bad_num_pf
      $error("NUM_PF must be in 1..2**PFID_W-1");
   end
   if (NUM_LVL < 1) begin : g_bad_num_lvl
      $error("NUM_LVL must be at least 1");
   end
   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("CNT_W must be at least 2");
   end

   ev_class_e cls;

   pft_classify #(
      .PFID_W  (PFID_W),
      .NUM_PF  (NUM_PF),
      .NUM_LVL (NUM_LVL),
      .LVL_W   (LVL_W)
   ) i_classify (
      .ev_valid   (ev_valid),
      .ev_hit     (ev_hit),
      .ev_demand  (ev_demand),
      .ev_lvl     (ev_lvl),
      .ev_line_id (ev_line_id),
      .ev_req_id  (ev_req_id),
      .cls        (cls)
   );

   logic step_up;
   logic step_dn;

   always_comb begin
      step_up = (cls == EV_DEM_HIT_PF) || (cls == EV_PF_HIT_PF);
      step_dn = (cls == EV_EVICT_PF);
   end

   for (genvar p = 0; p < NUM_PF; p++) begin : g_pf
      for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
         localparam int unsigned E = p * NUM_LVL + l;
         logic sel;
         always_comb sel = (ev_line_id == PFID_W'(p + 1)) && (ev_lvl == LVL_W'(l));

         pft_entry #(
            .CNT_W (CNT_W)
         ) i_entry (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (step_up && sel),
            .dec   (step_dn && sel),
            .cnt   (pf_cnt[E*CNT_W +: CNT_W]),
            .hint  (pf_hint[E])
         );
      end
   end

   pft_resp #(
      .PFID_W (PFID_W),
      .LVL_W  (LVL_W),
      .ADDR_W (ADDR_W),
      .PC_W   (PC_W)
   ) i_resp (
      .clk           (clk),
      .rst_n         (rst_n),
      .cls           (cls),
      .ev_lvl        (ev_lvl),
      .ev_req_id     (ev_req_id),
      .ev_addr       (ev_addr),
      .ev_pc         (ev_pc),
      .id_wr_valid   (id_wr_valid),
      .id_wr_value   (id_wr_value),
      .fp_add_valid  (fp_add_valid),
      .fp_add_addr   (fp_add_addr),
      .dem_upd_valid (dem_upd_valid),
      .dem_upd_lvl   (dem_upd_lvl),
      .dem_upd_pc    (dem_upd_pc)
   );

endmodule

// File: rtl/pft_checker.sv
module pft_checker #(
   parameter int unsigned NUM_PF  = 3,
   parameter int unsigned PFID_W  = 2,
   parameter int unsigned NUM_LVL = 2,
   parameter int unsigned CNT_W   = 3,
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned PC_W    = 16,
   parameter int unsigned LVL_W   = 1
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            ev_valid,
   input logic                            ev_hit,
   input logic                            ev_demand,
   input logic [LVL_W-1:0]                ev_lvl,
   input logic [PFID_W-1:0]               ev_line_id,
   input logic [PFID_W-1:0]               ev_req_id,
   input logic [ADDR_W-1:0]               ev_addr,
   input logic                            id_wr_valid,
   input logic [PFID_W-1:0]               id_wr_value,
   input logic                            fp_add_valid,
   input logic [ADDR_W-1:0]               fp_add_addr,
   input logic                            dem_upd_valid,
   input logic [NUM_PF*NUM_LVL*CNT_W-1:0] pf_cnt,
   input logic [NUM_PF*NUM_LVL-1:0]       pf_hint
);

   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   logic line_pf;
   logic lvl_ok;
   logic req_ok;
   always_comb begin
      line_pf = (ev_line_id != '0) && (32'(ev_line_id) <= NUM_PF);
      lvl_ok  = (32'(ev_lvl) < NUM_LVL);
      req_ok  = (ev_req_id != '0) && (32'(ev_req_id) <= NUM_PF);
   end

   // R3: demand hit on a prefetched line promotes it and feeds the demand side
   a_r3_demand_promotes: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && lvl_ok && ev_hit && ev_demand && line_pf)
      |=> (id_wr_valid && id_wr_value == '0 && fp_add_valid
           && fp_add_addr == $past(ev_addr) && dem_upd_valid));

   // R4: prefetch hit on a prefetched line keeps the identifier
   a_r4_pf_hit_keeps_id: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_hit && !ev_demand && line_pf)
      |=> (!id_wr_valid && !fp_add_valid && !dem_upd_valid));

   // R5: prefetch hit on a regular line claims it without training
   a_r5_claim_regular: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && lvl_ok && ev_hit && !ev_demand && ev_line_id == '0 && req_ok)
      |=> (id_wr_valid && id_wr_value == $past(ev_req_id)
           && $stable(pf_cnt) && $stable(pf_hint)));

   // R6: unused eviction never reaches the demand side
   a_r6_evict_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && !ev_hit) |=> (!id_wr_valid && !fp_add_valid && !dem_upd_valid));

   // R9: no event, no change
   a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_valid) |=> ($stable(pf_cnt) && $stable(pf_hint) && !id_wr_valid
                       && !fp_add_valid && !dem_upd_valid));

   // R3: the footprint add and the demand update travel together
   a_r3_requests_paired: assert property (@(posedge clk) disable iff (!rst_n)
      fp_add_valid == dem_upd_valid);

   for (genvar e = 0; e < NUM_PF * NUM_LVL; e++) begin : g_ent
      // R7: hint agrees with the counter at both ends of its range
      a_r7_hint_at_ends: assert property (@(posedge clk) disable iff (!rst_n)
         ((pf_cnt[e*CNT_W +: CNT_W] == CMAX) |-> pf_hint[e])
         and ((pf_cnt[e*CNT_W +: CNT_W] == '0) |-> !pf_hint[e]));
      // R8: a counter never jumps between its two ends
      a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(pf_cnt[e*CNT_W +: CNT_W]) == CMAX) |-> (pf_cnt[e*CNT_W +: CNT_W] != '0));
   end

endmodule

bind pf_reuse_trainer pft_checker #(
   .NUM_PF  (NUM_PF),
   .PFID_W  (PFID_W),
   .NUM_LVL (NUM_LVL),
   .CNT_W   (CNT_W),
   .ADDR_W  (ADDR_W),
   .PC_W    (PC_W),
   .LVL_W   (LVL_W)
) i_pft_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .ev_valid      (ev_valid),
   .ev_hit        (ev_hit),
   .ev_demand     (ev_demand),
   .ev_lvl        (ev_lvl),
   .ev_line_id    (ev_line_id),
   .ev_req_id     (ev_req_id),
   .ev_addr       (ev_addr),
   .id_wr_valid   (id_wr_valid),
   .id_wr_value   (id_wr_value),
   .fp_add_valid  (fp_add_valid),
   .fp_add_addr   (fp_add_addr),
   .dem_upd_valid (dem_upd_valid),
   .pf_cnt        (pf_cnt),
   .pf_hint       (pf_hint)
);

// File: tb/test_pf_reuse_trainer.sv
`timescale 1ns/1ps
module test_pf_reuse_trainer;

   localparam int NPF = 3;
   localparam int NLV = 2;
   localparam int CW  = 3;
   localparam int CMAX = 7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_valid = 1'b0;
   logic        ev_hit = 1'b0;
   logic        ev_demand = 1'b0;
   logic [0:0]  ev_lvl = '0;
   logic [1:0]  ev_line_id = '0;
   logic [1:0]  ev_req_id = '0;
   logic [15:0] ev_addr = '0;
   logic [15:0] ev_pc = '0;
   logic        id_wr_valid;
   logic [1:0]  id_wr_value;
   logic        fp_add_valid;
   logic [15:0] fp_add_addr;
   logic        dem_upd_valid;
   logic [0:0]  dem_upd_lvl;
   logic [15:0] dem_upd_pc;
   logic [NPF*NLV*CW-1:0] pf_cnt;
   logic [NPF*NLV-1:0]    pf_hint;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   int  m_cnt [NPF][NLV];
   bit  m_hint[NPF][NLV];

   always #2 clk = ~clk;

   pf_reuse_trainer i_pf_reuse_trainer (
      .clk (clk), .rst_n (rst_n),
      .ev_valid (ev_valid), .ev_hit (ev_hit), .ev_demand (ev_demand),
      .ev_lvl (ev_lvl), .ev_line_id (ev_line_id), .ev_req_id (ev_req_id),
      .ev_addr (ev_addr), .ev_pc (ev_pc),
      .id_wr_valid (id_wr_valid), .id_wr_value (id_wr_value),
      .fp_add_valid (fp_add_valid), .fp_add_addr (fp_add_addr),
      .dem_upd_valid (dem_upd_valid), .dem_upd_lvl (dem_upd_lvl),
      .dem_upd_pc (dem_upd_pc),
      .pf_cnt (pf_cnt), .pf_hint (pf_hint)
   );

   task automatic check(input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_tables(input string creq);
      for (int p = 0; p < NPF; p++) begin
         for (int l = 0; l < NLV; l++) begin
            int e = p * NLV + l;
            check(creq, $sformatf("counter pf%0d lvl%0d", p + 1, l),
                  longint'(pf_cnt[e*CW +: CW]), longint'(m_cnt[p][l]));
            check("R7", $sformatf("hint pf%0d lvl%0d", p + 1, l),
                  longint'(pf_hint[e]), longint'(m_hint[p][l]));
         end
      end
   endtask

   task automatic send(input bit valid, input bit hit, input bit demand,
                       input int lvl, input int line, input int req,
                       input int addr, input int pc);
      bit line_pf, dem_pf, pf_pf, pf_reg, evp, sat;
      string creq, oreq;
      @(negedge clk);
      ev_valid   = valid;
      ev_hit     = hit;
      ev_demand  = demand;
      ev_lvl     = 1'(lvl);
      ev_line_id = 2'(line);
      ev_req_id  = 2'(req);
      ev_addr    = 16'(addr);
      ev_pc      = 16'(pc);
      @(negedge clk);
      ev_valid = 1'b0;

      line_pf = (line >= 1 && line <= NPF);
      dem_pf  = valid && hit && demand && line_pf;
      pf_pf   = valid && hit && !demand && line_pf;
      pf_reg  = valid && hit && !demand && line == 0 && req >= 1 && req <= NPF;
      evp     = valid && !hit && line_pf;
      sat     = 1'b0;
      if (dem_pf || pf_pf) begin
         if (m_cnt[line-1][lvl] < CMAX) m_cnt[line-1][lvl]++;
         else sat = 1'b1;
         if (m_cnt[line-1][lvl] == CMAX) m_hint[line-1][lvl] = 1'b1;
      end
      if (evp) begin
         if (m_cnt[line-1][lvl] > 0) m_cnt[line-1][lvl]--;
         else sat = 1'b1;
         if (m_cnt[line-1][lvl] == 0) m_hint[line-1][lvl] = 1'b0;
      end

      creq = dem_pf ? "R2" : pf_pf ? "R4" : evp ? "R6" : pf_reg ? "R5" : "R9";
      oreq = dem_pf ? "R3" : pf_reg ? "R5" : pf_pf ? "R4" : evp ? "R6" : "R9";
      check_tables(creq);
      if (sat) begin
         check("R8", "saturated counter",
               longint'(pf_cnt[((line-1)*NLV+lvl)*CW +: CW]),
               longint'(m_cnt[line-1][lvl]));
      end
      check(oreq, "id_wr_valid", longint'(id_wr_valid), longint'(dem_pf || pf_reg));
      if (dem_pf || pf_reg)
         check(oreq, "id_wr_value", longint'(id_wr_value), dem_pf ? 0 : longint'(req));
      check(oreq, "fp_add_valid", longint'(fp_add_valid), longint'(dem_pf));
      check(oreq, "dem_upd_valid", longint'(dem_upd_valid), longint'(dem_pf));
      if (dem_pf) begin
         check("R3", "fp_add_addr", longint'(fp_add_addr), longint'(addr));
         check("R3", "dem_upd_lvl", longint'(dem_upd_lvl), longint'(lvl));
         check("R3", "dem_upd_pc", longint'(dem_upd_pc), longint'(pc));
         @(negedge clk);
         check("R3", "pulse ends", longint'(id_wr_valid || fp_add_valid || dem_upd_valid), 0);
      end
   endtask

   initial begin
      for (int p = 0; p < NPF; p++)
         for (int l = 0; l < NLV; l++) begin
            m_cnt[p][l]  = CMAX;
            m_hint[p][l] = 1'b1;
         end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check_tables("R1");
      check("R1", "outputs idle", longint'(id_wr_valid || fp_add_valid || dem_upd_valid), 0);

      // R9: invalid event with busy-looking fields
      send(1'b0, 1'b1, 1'b1, 0, 1, 2, 16'h1234, 16'h0abc);

      // sweep every prefetcher and level
      for (int p = 1; p <= NPF; p++) begin
         for (int l = 0; l < NLV; l++) begin
            // R6/R8/R7: drain to zero and one step past it
            for (int k = 0; k < CMAX + 1; k++)
               send(1'b1, 1'b0, 1'b0, l, p, 0, 16'h100 + k, 0);
            // R4/R7: prefetch hits climb, hint stays Bypass
            for (int k = 0; k < 3; k++)
               send(1'b1, 1'b1, 1'b0, l, p, (p % NPF) + 1, 16'h200 + k, 0);
            // R2/R3/R8: demand hits reach maximum and saturate
            for (int k = 0; k < 6; k++)
               send(1'b1, 1'b1, 1'b1, l, p, 0, 16'h300 + 16 * p + k, 16'h4000 + 8 * l + k);
            // R7: one eviction below max keeps Insert
            send(1'b1, 1'b0, 1'b0, l, p, 0, 16'h500, 0);
         end
      end

      // R5: prefetch hits on regular lines, every requester value
      for (int r = 0; r <= NPF; r++)
         for (int l = 0; l < NLV; l++)
            send(1'b1, 1'b1, 1'b0, l, 0, r, 16'h600 + r, 0);

      // R9: demand hit and eviction of regular lines
      for (int l = 0; l < NLV; l++) begin
         send(1'b1, 1'b1, 1'b1, l, 0, 1, 16'h700, 16'h77);
         send(1'b1, 1'b0, 1'b0, l, 0, 2, 16'h701, 0);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule